// File: doc/BRIEF.md
# Vector Memory Upload Port

This block is the write side of a vertex-engine storage bank whose entries are 128 bits wide. A host loads the bank through three write-only registers. It writes an entry pointer to the pointer register, then streams 32-bit words into the data register. Every fourth accepted word completes one 128-bit entry, which is stored at the current pointer. The pointer then steps to the next entry, so a long stream fills consecutive entries without another pointer write. All pointers count whole 16-byte entries.

The entry space has fixed regions. Program instructions start at entry 0x000. Program parameters start at entry 0x200. A single point-size vector of the form (0, 0, size, 0) lives at entry 0x406. After each committed entry, a two-bit flag reports which region that entry fell in.

A third register synchronises the host with the engine. Writing zero to it raises a wait flag. The flag stays up while any reader of the bank is still busy, so that new parameters are not picked up by work that is still running. A read-back port returns any stored entry, so that its contents can be checked.

Top module: `vmem_upload_port`

## Requirements
- R1: After a clock edge with rst_n low, entry_ptr is 0, last_region is 3 (unmapped), commit_pulse is 0 and sync_wait is 0.
- R2: The four words of a group are packed first-word-lowest: word 0 lands in bits [31:0], word 1 in [63:32], word 2 in [95:64] and word 3 in [127:96].
- R3: The edge that accepts the fourth word stores the entry, and the entry is visible on rd_data from that edge on. commit_pulse is high for exactly the one cycle that follows that edge.
- R4: Each committed entry advances entry_ptr by one, wrapping modulo 2^PTR_W, so that consecutive groups fill consecutive entries.
- R5: A write to the pointer register (wr_sel 0) loads entry_ptr from wr_data[PTR_W-1:0] and discards any partly filled group. Packing restarts at word 0, and no entry is written.
- R6: last_region encodes the region of the most recently committed entry. It is 0 for entries 0x000–0x1FF, 1 for entries 0x200–0x3FF, 2 for entry 0x406, and 3 for every other entry.
- R7: A write of zero to the flush register (wr_sel 2) sets sync_wait on the next edge. sync_wait stays high through every edge at which readers_busy is high. It clears at the first edge at which readers_busy is low.
- R8: Data writes (wr_sel 1) made while sync_wait is high are ignored. They are not counted toward a group.
- R9: A flush-register write with non-zero data is ignored, and so is any write with wr_sel 3.
- R10: A group committed at a pointer at or beyond BANK_DEPTH (1032 by default) is not stored, but the pointer still advances and the region is still reported. Read-back of such a pointer returns zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 pointer, 1 data, 2 flush, 3 none |
| wr_data | input | 32 | Write data |
| readers_busy | input | 1 | High while engine work may still read the bank |
| rd_ptr | input | PTR_W (11) | Read-back entry pointer |
| rd_data | output | 128 | Stored entry at rd_ptr; zero outside the bank |
| entry_ptr | output | PTR_W (11) | Entry that the next complete group will fill |
| commit_pulse | output | 1 | One-cycle strobe after an entry is committed |
| last_region | output | 2 | Region code of the last committed entry |
| sync_wait | output | 1 | Flush in progress; data writes are refused |

## Verification
The assertions assume that the host issues at most one register write per cycle, because wr_sel selects a single register. They also assume that the host leaves wr_sel and wr_data stable only while wr_en is high. Several properties go further and take it that a pointer load and a data write never meet in one cycle. The bench drives every write as a one-cycle strobe on the falling edge and releases it before the next write, so these assumptions always hold. readers_busy is only changed on the falling edge, away from any write, so that the stretch and release of sync_wait can be placed on known edges.

// File: rtl/vmu_pkg.sv
// Package: shared encodings for the vector memory upload port.
// Assumes: entry pointers are unsigned entry indices (16-byte units).
package vmu_pkg;
    localparam logic [1:0] SEL_PTR   = 2'd0;
    localparam logic [1:0] SEL_DATA  = 2'd1;
    localparam logic [1:0] SEL_FLUSH = 2'd2;

    localparam logic [1:0] RGN_PROG  = 2'd0;
    localparam logic [1:0] RGN_PARAM = 2'd1;
    localparam logic [1:0] RGN_PSIZE = 2'd2;
    localparam logic [1:0] RGN_NONE  = 2'd3;

    localparam int unsigned PROG_BASE   = 32'h000;
    localparam int unsigned PARAM_BASE  = 32'h200;
    localparam int unsigned REGION_LEN  = 32'h200;
    localparam int unsigned PSIZE_ENTRY = 32'h406;

    // Map an entry index to its region code.
    function automatic logic [1:0] region_of(input logic [31:0] p);
        if (p >= PROG_BASE && p < PROG_BASE + REGION_LEN)
            return RGN_PROG;
        else if (p >= PARAM_BASE && p < PARAM_BASE + REGION_LEN)
            return RGN_PARAM;
        else if (p == PSIZE_ENTRY)
            return RGN_PSIZE;
        else
            return RGN_NONE;
    endfunction
endpackage

// File: rtl/vmu_packer.sv
// Module: vmu_packer
// Gathers WORDS words into one entry and keeps the entry pointer.
// Assumes: ptr_load and word_valid are never high in the same cycle.
// A pointer load drops any partial group.
module vmu_packer #(
    parameter int PTR_W  = 11,
    parameter int WORD_W = 32,
    parameter int WORDS  = 4,
    localparam int ENTRY_W = WORD_W * WORDS,
    localparam int IDX_W   = $clog2(WORDS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ptr_load,
    input  logic [PTR_W-1:0]   ptr_value,
    input  logic               word_valid,
    input  logic [WORD_W-1:0]  word_in,
    output logic               commit_o,
    output logic [PTR_W-1:0]   commit_ptr_o,
    output logic [ENTRY_W-1:0] commit_data_o,
    output logic [PTR_W-1:0]   entry_ptr_o
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(WORDS - 1);

    logic [IDX_W-1:0]  word_idx_q;
    logic [PTR_W-1:0]  ptr_q;
    logic [WORD_W-1:0] lane_q [WORDS-1];

    // Commit when the final word of a group arrives.
    always_comb begin
        commit_o     = word_valid && (word_idx_q == LAST_IDX);
        commit_ptr_o = ptr_q;
        entry_ptr_o  = ptr_q;
    end

    // Assemble the entry: held lanes low, the arriving word on top.
    generate
        for (genvar g = 0; g < WORDS - 1; g++) begin : g_lane
            assign commit_data_o[g*WORD_W +: WORD_W] = lane_q[g];

            // Capture a word into its lane when that lane is next.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    lane_q[g] <= '0;
                else if (word_valid && word_idx_q == IDX_W'(g))
                    lane_q[g] <= word_in;
            end
        end
    endgenerate
    assign commit_data_o[(WORDS-1)*WORD_W +: WORD_W] = word_in;

    // Word counter and entry pointer update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_idx_q <= '0;
            ptr_q      <= '0;
        end else if (ptr_load) begin
            word_idx_q <= '0;
            ptr_q      <= ptr_value;
        end else if (word_valid) begin
            if (word_idx_q == LAST_IDX) begin
                word_idx_q <= '0;
                ptr_q      <= ptr_q + 1'b1;
            end else begin
                word_idx_q <= word_idx_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/vmu_bank.sv
// Module: vmu_bank
// Entry storage with one write port and a combinational read-back port.
// Assumes: writes to pointers at or beyond DEPTH are dropped, and reads
// of those pointers return zero.
module vmu_bank #(
    parameter int PTR_W   = 11,
    parameter int ENTRY_W = 128,
    parameter int DEPTH   = 1032
) (
    input  logic               clk,
    input  logic               we,
    input  logic [PTR_W-1:0]   wptr,
    input  logic [ENTRY_W-1:0] wdata,
    input  logic [PTR_W-1:0]   rptr,
    output logic [ENTRY_W-1:0] rdata
);
    localparam int AW = $clog2(DEPTH);

    logic [ENTRY_W-1:0] mem [DEPTH];

    logic w_in, r_in;
    always_comb begin
        w_in = (32'(wptr) < DEPTH);
        r_in = (32'(rptr) < DEPTH);
    end

    // Store a committed entry that falls inside the bank.
    always_ff @(posedge clk) begin
        if (we && w_in)
            mem[AW'(wptr)] <= wdata;
    end

    // Read back a stored entry, or zero outside the bank.
    always_comb begin
        rdata = r_in ? mem[AW'(rptr)] : '0;
    end
endmodule

// File: rtl/vmu_flush_ctl.sv
// Module: vmu_flush_ctl
// Holds the synchronise flag from a zero flush write until readers drain.
// Assumes: readers_busy is synchronous to clk.
module vmu_flush_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic flush_req,
    input  logic readers_busy,
    output logic wait_o
);
    logic pend_q;

    // Set on request; clear at the first edge with no busy reader.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pend_q <= 1'b0;
        else if (flush_req)
            pend_q <= 1'b1;
        else if (pend_q && !readers_busy)
            pend_q <= 1'b0;
    end

    assign wait_o = pend_q;
endmodule

// File: rtl/vmem_upload_port.sv
// Module: vmem_upload_port (top)
// Register-mapped upload port: a pointer register, a data register that
// packs words into entries, a flush register, and entry read-back.
// Assumes: one register write per cycle, selected by wr_sel.
module vmem_upload_port #(
    parameter int PTR_W      = 11,
    parameter int WORD_W     = 32,
    parameter int WORDS      = 4,
    parameter int BANK_DEPTH = 1032,
    localparam int ENTRY_W   = WORD_W * WORDS
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [1:0]         wr_sel,
    input  logic [WORD_W-1:0]  wr_data,
    input  logic               readers_busy,
    input  logic [PTR_W-1:0]   rd_ptr,
    output logic [ENTRY_W-1:0] rd_data,
    output logic [PTR_W-1:0]   entry_ptr,
    output logic               commit_pulse,
    output logic [1:0]         last_region,
    output logic               sync_wait
);
    import vmu_pkg::*;

    logic               ptr_load, word_valid, flush_req;
    logic               commit;
    logic [PTR_W-1:0]   commit_ptr;
    logic [ENTRY_W-1:0] commit_data;
    logic               commit_q;
    logic [1:0]         region_q;

    // Decode register writes; data is refused while a flush is waiting.
    always_comb begin
        ptr_load   = wr_en && (wr_sel == SEL_PTR);
        word_valid = wr_en && (wr_sel == SEL_DATA) && !sync_wait;
        flush_req  = wr_en && (wr_sel == SEL_FLUSH) && (wr_data == '0);
    end

    vmu_packer #(.PTR_W(PTR_W), .WORD_W(WORD_W), .WORDS(WORDS)) u_packer (
        .clk          (clk),
        .rst_n        (rst_n),
        .ptr_load     (ptr_load),
        .ptr_value    (wr_data[PTR_W-1:0]),
        .word_valid   (word_valid),
        .word_in      (wr_data),
        .commit_o     (commit),
        .commit_ptr_o (commit_ptr),
        .commit_data_o(commit_data),
        .entry_ptr_o  (entry_ptr)
    );

    vmu_bank #(.PTR_W(PTR_W), .ENTRY_W(ENTRY_W), .DEPTH(BANK_DEPTH)) u_bank (
        .clk  (clk),
        .we   (commit),
        .wptr (commit_ptr),
        .wdata(commit_data),
        .rptr (rd_ptr),
        .rdata(rd_data)
    );

    vmu_flush_ctl u_flush (
        .clk         (clk),
        .rst_n       (rst_n),
        .flush_req   (flush_req),
        .readers_busy(readers_busy),
        .wait_o      (sync_wait)
    );

    // Commit strobe and region flag of the last stored entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            commit_q <= 1'b0;
            region_q <= RGN_NONE;
        end else begin
            commit_q <= commit;
            if (commit)
                region_q <= region_of(32'(commit_ptr));
        end
    end

    assign commit_pulse = commit_q;
    assign last_region  = region_q;
endmodule

// File: rtl/vmu_checker.sv
// Module: vmu_checker
// Temporal checks on the upload port, attached to the top through bind.
// Assumes: the environment presents one register write per cycle.
module vmu_checker #(
    parameter int PTR_W  = 11,
    parameter int WORD_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [1:0]        wr_sel,
    input logic [WORD_W-1:0] wr_data,
    input logic              readers_busy,
    input logic [PTR_W-1:0]  entry_ptr,
    input logic              commit_pulse,
    input logic [1:0]        last_region,
    input logic              sync_wait
);
    import vmu_pkg::*;

    AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        commit_pulse |-> entry_ptr == $past(entry_ptr) + 1'b1); // R4

    AST_COMMIT_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        commit_pulse |-> $past(wr_en && wr_sel == SEL_DATA && !sync_wait)); // R8

    AST_PTR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == SEL_PTR) |=> entry_ptr == $past(wr_data[PTR_W-1:0])); // R5

    AST_NO_COMMIT_ON_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == SEL_PTR) |=> !commit_pulse); // R5

    AST_WAIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_wait && readers_busy) |=> sync_wait); // R7

    AST_WAIT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_wait && !readers_busy && !(wr_en && wr_sel == SEL_FLUSH)) |=> !sync_wait); // R7

    AST_WAIT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sync_wait) |-> $past(wr_en && wr_sel == SEL_FLUSH && wr_data == '0)); // R9

    AST_REGION_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        commit_pulse |-> last_region == region_of(32'($past(entry_ptr)))); // R6

    AST_REGION_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !commit_pulse |-> $stable(last_region)); // R6
endmodule

bind vmem_upload_port vmu_checker #(.PTR_W(PTR_W), .WORD_W(WORD_W)) u_vmu_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .wr_sel      (wr_sel),
    .wr_data     (wr_data),
    .readers_busy(readers_busy),
    .entry_ptr   (entry_ptr),
    .commit_pulse(commit_pulse),
    .last_region (last_region),
    .sync_wait   (sync_wait)
);

// File: tb/test_vmem_upload_port.sv
// Bench for vmem_upload_port. A vector table drives whole-entry uploads,
// then directed tests cover reset and the corner cases.
module test_vmem_upload_port;
    localparam int PTR_W = 11;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wr_en = 1'b0;
    logic [1:0]   wr_sel = 2'd3;
    logic [31:0]  wr_data = '0;
    logic         readers_busy = 1'b0;
    logic [10:0]  rd_ptr = '0;
    logic [127:0] rd_data;
    logic [10:0]  entry_ptr;
    logic         commit_pulse;
    logic [1:0]   last_region;
    logic         sync_wait;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    vmem_upload_port i_vmem_upload_port (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .readers_busy(readers_busy), .rd_ptr(rd_ptr),
        .rd_data(rd_data), .entry_ptr(entry_ptr), .commit_pulse(commit_pulse),
        .last_region(last_region), .sync_wait(sync_wait)
    );

    localparam int NV = 7;
    localparam logic [10:0] VP [NV] = '{11'h000, 11'h1FF, 11'h200, 11'h3FF,
                                        11'h406, 11'h405, 11'h400};
    localparam logic [1:0]  VR [NV] = '{2'd0, 2'd0, 2'd1, 2'd1, 2'd2, 2'd3, 2'd3};
    localparam logic [127:0] VD [NV] = '{
        128'h0000000F_0000000E_0000000D_0000000C,
        128'hDEADBEEF_01234567_89ABCDEF_FEEDFACE,
        128'h11111111_22222222_33333333_44444444,
        128'hA5A5A5A5_5A5A5A5A_FFFFFFFF_00000001,
        128'h00000000_3F800000_00000000_00000000,
        128'h80000000_00000001_7FFFFFFF_CAFEF00D,
        128'h0BADC0DE_FACEB00C_12345678_9ABCDEF0};

    task automatic chk(input bit ok, input string req, input logic [127:0] act,
                       input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] sel, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_sel = 2'd3; wr_data = '0;
    endtask

    // Writes the four words of an entry, lowest word first.
    task automatic put_entry(input logic [127:0] e);
        for (int k = 0; k < 4; k++) wr(2'd1, e[k*32 +: 32]);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [127:0] e;
        repeat (3) @(negedge clk);
        // R1: state right after reset
        chk(entry_ptr == 0, "R1 ptr", 128'(entry_ptr), 0);
        chk(last_region == 2'd3, "R1 region", 128'(last_region), 3);
        chk(!commit_pulse && !sync_wait, "R1 flags", {commit_pulse, sync_wait}, 0);
        rst_n = 1'b1;

        // Table walk: R2 packing, R3 commit, R6 region
        for (int v = 0; v < NV; v++) begin
            wr(2'd0, 32'(VP[v]));
            put_entry(VD[v]);
            chk(commit_pulse == 1'b1, "R3 pulse", 128'(commit_pulse), 1);
            rd_ptr = VP[v];
            #1;
            chk(rd_data == VD[v], "R2 data", rd_data, VD[v]);
            chk(last_region == VR[v], "R6 region", 128'(last_region), 128'(VR[v]));
            chk(entry_ptr == VP[v] + 11'd1, "R4 step", 128'(entry_ptr), 128'(VP[v] + 11'd1));
            @(negedge clk);
            chk(commit_pulse == 1'b0, "R3 one cycle", 128'(commit_pulse), 0);
        end

        // R4: two back-to-back groups fill consecutive entries
        wr(2'd0, 32'h020);
        put_entry({4{32'h0000AAAA}});
        put_entry({4{32'h0000BBBB}});
        rd_ptr = 11'h020; #1;
        chk(rd_data == {4{32'h0000AAAA}}, "R4 first", rd_data, {4{32'h0000AAAA}});
        rd_ptr = 11'h021; #1;
        chk(rd_data == {4{32'h0000BBBB}}, "R4 second", rd_data, {4{32'h0000BBBB}});
        chk(entry_ptr == 11'h022, "R4 ptr", 128'(entry_ptr), 128'h22);

        // R5: a pointer write drops a partial group
        wr(2'd0, 32'h030);
        put_entry({4{32'h00001111}});
        wr(2'd1, 32'hBAD00001);
        wr(2'd1, 32'hBAD00002);
        wr(2'd0, 32'h031);
        chk(commit_pulse == 1'b0, "R5 no commit", 128'(commit_pulse), 0);
        e = 128'h44444444_33333333_22222222_11111111;
        put_entry(e);
        rd_ptr = 11'h031; #1;
        chk(rd_data == e, "R5 restart", rd_data, e);
        rd_ptr = 11'h030; #1;
        chk(rd_data == {4{32'h00001111}}, "R5 untouched", rd_data, {4{32'h00001111}});

        // R7 and R8: flush stall while readers are busy; data refused
        @(negedge clk); readers_busy = 1'b1;
        wr(2'd0, 32'h040);
        wr(2'd2, 32'h0);
        chk(sync_wait == 1'b1, "R7 set", 128'(sync_wait), 1);
        wr(2'd1, 32'hDEAD0000);
        repeat (3) @(negedge clk);
        chk(sync_wait == 1'b1, "R7 hold", 128'(sync_wait), 1);
        readers_busy = 1'b0;
        @(negedge clk);
        chk(sync_wait == 1'b0, "R7 release", 128'(sync_wait), 0);
        e = 128'h0D0D0D0D_0C0C0C0C_0B0B0B0B_0A0A0A0A;
        put_entry(e);
        rd_ptr = 11'h040; #1;
        chk(rd_data == e, "R8 ignored word", rd_data, e);

        // R7: flush with no busy reader clears after one edge
        wr(2'd2, 32'h0);
        chk(sync_wait == 1'b1, "R7 short set", 128'(sync_wait), 1);
        @(negedge clk);
        chk(sync_wait == 1'b0, "R7 short clear", 128'(sync_wait), 0);

        // R9: non-zero flush data and select 3 change nothing
        wr(2'd2, 32'h5);
        chk(sync_wait == 1'b0, "R9 nonzero flush", 128'(sync_wait), 0);
        wr(2'd0, 32'h050);
        wr(2'd3, 32'h77777777);
        e = 128'h00000004_00000003_00000002_00000001;
        put_entry(e);
        rd_ptr = 11'h050; #1;
        chk(rd_data == e, "R9 select 3", rd_data, e);

        // R10: beyond the bank, not stored; pointer advances and wraps
        wr(2'd0, 32'h500);
        put_entry({4{32'hFFFFFFFF}});
        rd_ptr = 11'h500; #1;
        chk(rd_data == '0, "R10 not stored", rd_data, 0);
        chk(last_region == 2'd3, "R10 region", 128'(last_region), 3);
        chk(entry_ptr == 11'h501, "R10 ptr", 128'(entry_ptr), 128'h501);
        wr(2'd0, 32'h7FF);
        put_entry({4{32'h12121212}});
        chk(entry_ptr == 11'h000, "R4 wrap", 128'(entry_ptr), 0);

        // R1: reset mid-group returns the state to its reset values
        wr(2'd1, 32'h1);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk);
        chk(entry_ptr == 0 && last_region == 2'd3, "R1 re-reset",
            {entry_ptr, last_region}, 128'h3);
        rst_n = 1'b1;

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule